// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block keeps the return addresses of a small 8-bit controller core in an eight-entry last-in-first-out store. A subroutine call or an interrupt entry pushes the address presented on `push_addr`. A return or return-from-interrupt pops the newest entry. The address to reload into the program counter is shown combinationally on `ret_addr` in the same cycle as the pop request, and the stack moves on the following clock edge.

The store is a circular buffer of registers. A call made while all eight slots are in use still writes its address, and the oldest address is lost. Interrupt entry is handled differently: while the stack is full, a pending, enabled interrupt request is not acknowledged. It stays pending until a return frees a slot for its return address. The address width is a parameter. The depth is a power-of-two parameter with a default of 8.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous active-high reset the stack is empty: `stack_full` is 0, and exactly eight pushes are needed before `stack_full` rises again.
- R2: While the stack is not empty, `ret_addr` equals the most recently pushed address that has not yet been popped, so pops return addresses in reverse push order.
- R3: `stack_full` is 1 exactly when eight addresses are held.
- R4: A push while full stores the new address, keeps `stack_full` at 1 and discards the oldest entry. The following eight pops return the eight newest addresses, newest first.
- R5: A pop on an empty stack changes nothing. The stack stays empty, and a later push followed by a pop returns the pushed address.
- R6: A push and a pop in the same cycle on a non-empty stack first return the current top on `ret_addr`, then replace the top with `push_addr`. The occupancy is unchanged.
- R7: A push and a pop in the same cycle on an empty stack act as a single push, leaving one entry.
- R8: `irq_ack` is 1 exactly when `irq_pending` is 1, `irq_enable` is 1 and `stack_full` is 0.
- R9: A pop without a push on a full stack clears `stack_full` on the next cycle, which lets a held interrupt be acknowledged.
- R10: A push from interrupt entry (`irq_push`) stores and orders addresses exactly like a push from a call (`call_push`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_push | input | 1 | Push request from a subroutine call |
| irq_push | input | 1 | Push request from interrupt entry |
| ret_pop | input | 1 | Pop request from a return or return-from-interrupt |
| push_addr | input | AW | Return address to store on a push |
| irq_pending | input | 1 | An interrupt request is pending |
| irq_enable | input | 1 | Interrupts are unmasked |
| ret_addr | output | AW | Current top-of-stack address, the value a pop returns |
| stack_full | output | 1 | All slots are occupied |
| irq_ack | output | 1 | Interrupt acknowledge gate |

## Verification
The hardest case to reach is a long run of pushes past the eighth. Only there does the circular index wrap while the occupancy stays saturated, and only a full drain afterwards shows which addresses were dropped. Random stimulus runs in phases that favour pushes and then phases that favour pops, so the stack repeatedly overflows and empties under a reference queue model. Directed sequences add a full-stack interrupt hold and its release by a return, simultaneous push and pop on both an empty and a non-empty stack, and pops from an empty stack.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_SWAP
    } ras_op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } ras_req_t;

    // A pop on an empty stack is dropped; a push with a pop replaces the top.
    function automatic ras_op_e decode_op(input ras_req_t req, input logic empty);
        if (req.push && req.pop && !empty) return OP_SWAP;
        if (req.push)                      return OP_PUSH;
        if (req.pop && !empty)             return OP_POP;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ras_req_t      req,
    output logic          wr_en,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] rd_slot,
    output logic [CW-1:0] occ_count,
    output logic          full
);

    logic [PW-1:0] wr_idx;
    logic [PW-1:0] top_idx;
    logic          empty;
    ras_op_e       op;

    assign empty   = (occ_count == '0);
    assign full    = (occ_count == CW'(DEPTH));
    assign top_idx = wr_idx - 1'b1;
    assign op      = decode_op(req, empty);
    assign rd_slot = top_idx;

    always_comb begin
        wr_en   = 1'b0;
        wr_slot = wr_idx;
        case (op)
            OP_PUSH: begin
                wr_en   = 1'b1;
                wr_slot = wr_idx;
            end
            OP_SWAP: begin
                wr_en   = 1'b1;
                wr_slot = top_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx    <= '0;
            occ_count <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    wr_idx <= wr_idx + 1'b1;
                    if (!full) occ_count <= occ_count + 1'b1;
                end
                OP_POP: begin
                    wr_idx    <= top_idx;
                    occ_count <= occ_count - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_slot,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_slot,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_slot == PW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
    input  logic pending,
    input  logic enable,
    input  logic full,
    output logic ack
);

    // A held request keeps waiting until a slot is free for its address.
    assign ack = pending & enable & ~full;

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_push,
    input  logic          irq_push,
    input  logic          ret_pop,
    input  logic [AW-1:0] push_addr,
    input  logic          irq_pending,
    input  logic          irq_enable,
    output logic [AW-1:0] ret_addr,
    output logic          stack_full,
    output logic          irq_ack
);

    ras_req_t      req;
    logic          wr_en;
    logic [PW-1:0] wr_slot;
    logic [PW-1:0] rd_slot;
    logic [CW-1:0] occ_count;

    assign req.push = call_push | irq_push;
    assign req.pop  = ret_pop;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot),
        .occ_count (occ_count),
        .full      (stack_full)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (push_addr),
        .rd_slot (rd_slot),
        .rd_data (ret_addr)
    );

    ras_irq_gate u_gate (
        .pending (irq_pending),
        .enable  (irq_enable),
        .full    (stack_full),
        .ack     (irq_ack)
    );

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
    parameter int AW    = 12,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          call_push,
    input logic          irq_push,
    input logic          ret_pop,
    input logic [AW-1:0] push_addr,
    input logic          irq_pending,
    input logic          irq_enable,
    input logic [AW-1:0] ret_addr,
    input logic          stack_full,
    input logic          irq_ack,
    input logic [CW-1:0] occ_count
);

    logic any_push;
    assign any_push = call_push | irq_push;

    a_r1_empty_after_reset: assert property (@(posedge clk) rst |=> (occ_count == '0));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ_count <= CW'(DEPTH));

    a_r4_full_sticks: assert property (@(posedge clk) disable iff (rst)
        (stack_full && any_push && !ret_pop) |=> stack_full);

    a_r2_top_is_last_push: assert property (@(posedge clk) disable iff (rst)
        (any_push && !ret_pop) |=> (ret_addr == $past(push_addr)));

    a_r5_empty_pop_stays: assert property (@(posedge clk) disable iff (rst)
        (occ_count == '0 && ret_pop && !any_push) |=> (occ_count == '0));

    a_r6_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (occ_count != '0 && ret_pop && any_push) |=>
            (occ_count == $past(occ_count) && ret_addr == $past(push_addr)));

    a_r8_no_ack_when_full: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> !irq_ack);

    a_r8_ack_needs_request: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (irq_pending && irq_enable));

    a_r9_pop_frees_slot: assert property (@(posedge clk) disable iff (rst)
        (stack_full && ret_pop && !any_push) |=> !stack_full);

endmodule

bind ret_addr_stack ret_addr_stack_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .call_push   (call_push),
    .irq_push    (irq_push),
    .ret_pop     (ret_pop),
    .push_addr   (push_addr),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .ret_addr    (ret_addr),
    .stack_full  (stack_full),
    .irq_ack     (irq_ack),
    .occ_count   (occ_count)
);

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;

    localparam int AW    = 12;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_push = 1'b0;
    logic          irq_push = 1'b0;
    logic          ret_pop = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          irq_pending = 1'b0;
    logic          irq_enable = 1'b0;
    logic [AW-1:0] ret_addr;
    logic          stack_full;
    logic          irq_ack;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;
    logic [AW-1:0] model_q[$];

    always #10 clk = ~clk;

    ret_addr_stack #(.AW(AW), .DEPTH(DEPTH)) i_ret_addr_stack (
        .clk(clk), .rst(rst), .call_push(call_push), .irq_push(irq_push),
        .ret_pop(ret_pop), .push_addr(push_addr), .irq_pending(irq_pending),
        .irq_enable(irq_enable), .ret_addr(ret_addr), .stack_full(stack_full),
        .irq_ack(irq_ack)
    );

    function automatic bit exp_full();
        return model_q.size() == DEPTH;
    endfunction

    function automatic bit exp_ack(input bit pend, input bit en);
        return pend && en && !exp_full();
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; call_push = 0; irq_push = 0; ret_pop = 0;
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
    endtask

    // Drive one cycle, check outputs before the edge, then advance the model.
    task automatic step(input bit c, input bit i, input bit p, input logic [AW-1:0] a,
                        input bit pend, input bit en, input string rq);
        @(negedge clk);
        call_push = c; irq_push = i; ret_pop = p; push_addr = a;
        irq_pending = pend; irq_enable = en;
        #2;
        chk(stack_full == exp_full(), {rq, " R3 stack_full"}, stack_full, exp_full());
        chk(irq_ack == exp_ack(pend, en), {rq, " R8 irq_ack"}, irq_ack, exp_ack(pend, en));
        if (p && model_q.size() > 0)
            chk(ret_addr == model_q[$], {rq, " R2 ret_addr"}, ret_addr, model_q[$]);
        @(posedge clk);
        if (p && model_q.size() > 0) void'(model_q.pop_back());
        if (c || i) begin
            model_q.push_back(a);
            if (model_q.size() > DEPTH) void'(model_q.pop_front());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A5E_0042));
        do_reset();

        // R1: reset state
        #2;
        chk(stack_full == 1'b0, "R1 full after reset", stack_full, 0);

        // R3/R8: fill with an interrupt pending; ack drops once full
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, AW'(12'h100 + k), 1, 1, "R3 fill");
        step(0, 0, 0, '0, 1, 1, "R8 held while full");
        // R4: overflow by three, then drain to see the oldest three were dropped
        for (int k = 0; k < 3; k++) step(1, 0, 0, AW'(12'h200 + k), 1, 1, "R4 overflow");
        step(0, 0, 0, '0, 0, 1, "R4 still full");
        // R9: one pop frees a slot, the held interrupt is acknowledged next cycle
        step(0, 0, 1, '0, 1, 1, "R9 pop from full");
        step(0, 0, 0, '0, 1, 1, "R9 ack released");
        for (int k = 0; k < DEPTH - 1; k++) step(0, 0, 1, '0, 0, 0, "R4 drain order");
        // R5: pops on an empty stack
        for (int k = 0; k < 3; k++) step(0, 0, 1, '0, 1, 1, "R5 empty pop");
        step(1, 0, 0, 12'h3C3, 0, 0, "R5 push after empty pop");
        step(0, 0, 1, '0, 0, 0, "R5 pop returns pushed");
        // R7: push with pop on an empty stack acts as a push
        step(1, 0, 1, 12'h4D4, 0, 0, "R7 both on empty");
        step(0, 0, 1, '0, 0, 0, "R7 single entry");
        step(0, 0, 1, '0, 0, 0, "R7 now empty");
        // R6: push with pop on a non-empty stack replaces the top
        step(1, 0, 0, 12'h511, 0, 0, "R6 setup");
        step(1, 0, 0, 12'h522, 0, 0, "R6 setup");
        step(0, 1, 1, 12'h5EE, 0, 0, "R6 swap");
        step(0, 0, 1, '0, 0, 0, "R6 new top");
        step(0, 0, 1, '0, 0, 0, "R6 below untouched");
        // R10: interrupt-entry pushes fill and order like calls
        for (int k = 0; k < DEPTH + 1; k++) step(0, 1, 0, AW'(12'h600 + k), 1, 1, "R10 irq push");
        for (int k = 0; k < DEPTH; k++) step(0, 0, 1, '0, 1, 1, "R10 irq pop");
        // R1: reset mid-run with contents present
        for (int k = 0; k < 5; k++) step(1, 0, 0, AW'(12'h700 + k), 0, 0, "R1 pre-reset");
        do_reset();
        #2;
        chk(stack_full == 1'b0, "R1 full after second reset", stack_full, 0);
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, AW'(12'h800 + k), 1, 1, "R1 refill");
        step(0, 0, 0, '0, 1, 1, "R1 full after eight");

        // Random phases: push-heavy, then pop-heavy
        for (int k = 0; k < 4000; k++) begin
            automatic bit heavy = ((k / 150) % 2) == 0;
            automatic int r = $urandom_range(0, 9);
            automatic bit c = heavy ? (r < 5) : (r < 2);
            automatic bit i = (r == 5);
            automatic bit p = heavy ? (r >= 8) : (r >= 4);
            step(c, i, p, AW'($urandom), 1'($urandom), 1'($urandom), "rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule